// File: doc/BRIEF.md
# Serial DAC Word Receiver and Output Latch

This block is the digital front end of a 14-bit serial-input digital-to-analog converter. A host sends words over a three-wire link made of an active-low frame select, a serial clock and a data line. The block samples all three lines in a faster system clock domain and shifts the data into a frame register. When the frame select rises, the block checks the frame and copies the 14 code bits into the parallel latch that drives the converter.

A frame holds 16 bits. The 14 code bits come first, most significant first. Two padding bits follow, and the sender should set them to zero. If the frame select rises after any number of clock edges other than 16, the frame is dropped, the latch keeps its value and an error pulse appears. An active-low clear input forces the latch at once to a reset code. The same code is loaded at power-on reset. A static strap picks the code: zero for unipolar use, or midscale (offset-binary zero) for bipolar use.

The system clock must run at least four times faster than the serial clock. The serial inputs each pass through two flops before edges are detected.

Top module: `sdac_front`

## Requirements
- R1: In an accepted frame, the first 14 bits received after frame select falls become the latch value, with the first bit as bit 13 and the fourteenth bit as bit 0.
- R2: The latch changes from a frame only when frame select (csn_in) rises after exactly 16 rising serial-clock edges while it was low. The new value and the update strobe appear 4 system clocks after the rising edge of csn_in is applied.
- R3: When frame select rises after a count other than 16 (including zero, 15 and 17), the latch keeps its value and frame_err is high for exactly one system clock. frame_err appears in the same cycle an update strobe would have appeared.
- R4: Bits 15 and 16 of a frame are padding and never reach the latch. pad_flag holds the OR of the two padding bits of the most recent accepted frame, and is 0 after reset.
- R5: A low level on clr_n forces dac_code to the reset code without waiting for a system clock edge.
- R6: The reset code is 0x0000 when bipolar_sel is 0 and 0x2000 (midscale, offset-binary zero) when it is 1. A synchronous low on rst_n loads the same code, clears upd_pulse, frame_err and pad_flag, and resets the frame counter.
- R7: While clr_n is low, frames still shift in but cannot update the latch, and no update strobe is produced. After clr_n goes high, the reset code stays until the next accepted frame.
- R8: upd_pulse is high for exactly one system clock for each frame written into the latch, and never in the same cycle as frame_err.
- R9: Serial-clock edges while frame select is high do not shift data or count. Each falling edge of frame select restarts the bit count, so a good frame after an aborted one is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of the output latch |
| bipolar_sel | input | 1 | Static strap: 1 selects the midscale reset code, 0 selects zero |
| csn_in | input | 1 | Active-low frame select from the host |
| sclk_in | input | 1 | Serial clock from the host; data is taken on its rising edge |
| sdi_in | input | 1 | Serial data from the host, most significant bit first |
| dac_code | output | 14 | Latched converter code |
| upd_pulse | output | 1 | One-cycle strobe when a frame is written into the latch |
| frame_err | output | 1 | One-cycle strobe when a frame of the wrong length is dropped |
| pad_flag | output | 1 | Set when a padding bit of the last accepted frame was nonzero |

## Verification
From the system clock edge that first sees frame select high, the latch value and upd_pulse or frame_err are due on the fourth edge. Two synchronizer flops, one edge-detect flop and the latch flop make up that delay. The bench drives every input on the falling clock edge and then watches the strobes on each of the next eight falling edges. It records the index at which each strobe is seen and expects exactly 4 for a strobe that should occur, and no strobe at all otherwise. The code and pad_flag are read after that window. The clear is checked one nanosecond after it is driven, before any rising edge, so it is shown to act without a clock. A held clear is checked again a few cycles after release, to confirm the reset code remains.

// File: rtl/sdac_pkg.sv
// Shared constants for the serial DAC front end.
// Assumes a frame is the code word followed by a fixed count of padding bits.
package sdac_pkg;

    localparam int CODE_BITS_DEF = 14;   // converter resolution
    localparam int PAD_BITS_DEF  = 2;    // padding bits after the code
    localparam int SYNC_DEPTH    = 2;    // synchronizer flops per serial input

    // Reset code chosen by the polarity strap: zero or midscale.
    function automatic logic [31:0] reset_code(input int unsigned width, input logic bipolar);
        logic [31:0] v;
        v = 32'd0;
        if (bipolar) v = 32'd1 << (width - 1);
        return v;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
// Multi-flop synchronizer for a bundle of slow asynchronous inputs.
// Assumes each input stays stable for longer than STAGES system clocks.
module sdac_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Move the inputs one flop further down the chain on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sdac_frame_rx.sv
// Frame receiver: detects serial clock and frame-select edges, shifts data
// and counts bits. It reports each closed frame with a one-cycle done strobe
// and a length-ok bit. Assumes inputs are already synchronized to clk.
module sdac_frame_rx #(
    parameter int CODE_W = 14,
    parameter int PAD_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     csn_s,
    input  logic                     sclk_s,
    input  logic                     sdi_s,
    output logic                     done,
    output logic                     len_ok,
    output logic [CODE_W+PAD_W-1:0]  word
);

    localparam int FRAME_W = CODE_W + PAD_W;
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    logic             sclk_d, csn_d;
    logic             sclk_rise, cs_fall, cs_rise, shift_en;
    logic [CNT_W-1:0] cnt;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_fall = ~csn_s & csn_d;
    assign cs_rise = csn_s & ~csn_d;
    assign shift_en = ~csn_s & sclk_rise;

    // Keep the previous level of the clock and select lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d <= csn_s;
        end
    end

    // Count received bits, saturating one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cs_fall) cnt <= '0;
        else if (shift_en && cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end

    // Shift data in, most significant bit first.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else if (shift_en) word <= {word[FRAME_W-2:0], sdi_s};
    end

    // Report a closed frame and whether its length was exactly right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            len_ok <= 1'b0;
        end else begin
            done <= cs_rise;
            len_ok <= cs_rise && (cnt == CNT_FULL);
        end
    end

endmodule

// File: rtl/sdac_latch.sv
// Output latch with asynchronous clear. It takes the code field of each
// frame that has the right length and raises the update, error and padding
// flags. Assumes bipolar_sel is static while out of reset.
module sdac_latch #(
    parameter int CODE_W = 14,
    parameter int PAD_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_n,
    input  logic                    bipolar_sel,
    input  logic                    done,
    input  logic                    len_ok,
    input  logic [CODE_W+PAD_W-1:0] word,
    output logic [CODE_W-1:0]       code,
    output logic                    upd,
    output logic                    err,
    output logic                    pad_nz
);

    import sdac_pkg::*;

    localparam int FRAME_W = CODE_W + PAD_W;
    localparam logic [CODE_W-1:0] CODE_UNI = CODE_W'(reset_code(CODE_W, 1'b0));
    localparam logic [CODE_W-1:0] CODE_BIP = CODE_W'(reset_code(CODE_W, 1'b1));

    logic [CODE_W-1:0] rst_code;
    logic [1:0]        clr_q;
    logic              clr_ok, accept;

    assign rst_code = bipolar_sel ? CODE_BIP : CODE_UNI;
    assign clr_ok = clr_q[1];
    assign accept = done && len_ok && clr_ok;

    // Assert at once, release in step with clk: the clear as seen by the latch.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) clr_q <= 2'b00;
        else clr_q <= {clr_q[0], 1'b1};
    end

    // Latch register: cleared at once, reloaded while clear settles, written by good frames.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) code <= rst_code;
        else if (!rst_n || !clr_ok) code <= rst_code;
        else if (accept) code <= word[FRAME_W-1 -: CODE_W];
    end

    // Update and error strobes, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd <= 1'b0;
            err <= 1'b0;
        end else begin
            upd <= accept;
            err <= done && !len_ok;
        end
    end

    // Padding status taken from each accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) pad_nz <= 1'b0;
        else if (accept) pad_nz <= |word[PAD_W-1:0];
    end

endmodule

// File: rtl/sdac_front.sv
// Top of the serial DAC front end: synchronizers, frame receiver and output
// latch. Assumes clk runs at least four times faster than sclk_in.
module sdac_front #(
    parameter int CODE_W = sdac_pkg::CODE_BITS_DEF,
    parameter int PAD_W = sdac_pkg::PAD_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              bipolar_sel,
    input  logic              csn_in,
    input  logic              sclk_in,
    input  logic              sdi_in,
    output logic [CODE_W-1:0] dac_code,
    output logic              upd_pulse,
    output logic              frame_err,
    output logic              pad_flag
);

    localparam int FRAME_W = CODE_W + PAD_W;

    logic [2:0]         sync_q;
    logic               done, len_ok;
    logic [FRAME_W-1:0] word;

    sdac_sync #(
        .WIDTH(3),
        .STAGES(sdac_pkg::SYNC_DEPTH),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst_n(rst_n),
        .d({csn_in, sclk_in, sdi_in}),
        .q(sync_q)
    );

    sdac_frame_rx #(.CODE_W(CODE_W), .PAD_W(PAD_W)) u_rx (
        .clk(clk),
        .rst_n(rst_n),
        .csn_s(sync_q[2]),
        .sclk_s(sync_q[1]),
        .sdi_s(sync_q[0]),
        .done(done),
        .len_ok(len_ok),
        .word(word)
    );

    sdac_latch #(.CODE_W(CODE_W), .PAD_W(PAD_W)) u_latch (
        .clk(clk),
        .rst_n(rst_n),
        .clr_n(clr_n),
        .bipolar_sel(bipolar_sel),
        .done(done),
        .len_ok(len_ok),
        .word(word),
        .code(dac_code),
        .upd(upd_pulse),
        .err(frame_err),
        .pad_nz(pad_flag)
    );

endmodule

// File: rtl/sdac_front_checks.sv
// Port-level properties of the serial DAC front end, bound to the top.
module sdac_front_checks #(
    parameter int CODE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              bipolar_sel,
    input logic [CODE_W-1:0] dac_code,
    input logic              upd_pulse,
    input logic              frame_err
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    // The update strobe lasts one cycle.
    assert_upd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse);

    // The error strobe lasts one cycle.
    assert_err_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // A frame is either written or dropped, never both.
    assert_upd_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_pulse && frame_err));

    // Outside reset and clear, the code moves only together with an update strobe.
    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_n) && clr_n && !upd_pulse) |-> $stable(dac_code));

    // While clear is low, the code sits at the strap-selected reset value.
    assert_clear_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == (bipolar_sel ? MID : '0)));

    // No update strobe can follow a clock edge that saw clear low.
    assert_no_upd_in_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !upd_pulse);

endmodule

bind sdac_front sdac_front_checks #(.CODE_W(CODE_W)) u_checks (
    .clk(clk),
    .rst_n(rst_n),
    .clr_n(clr_n),
    .bipolar_sel(bipolar_sel),
    .dac_code(dac_code),
    .upd_pulse(upd_pulse),
    .frame_err(frame_err)
);

// File: tb/sdac_front_bench.sv
// Self-checking bench for sdac_front: a table of frames, then directed cases.
module sdac_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        bipolar_sel = 1'b0;
    logic        csn_in = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sdi_in = 1'b0;
    logic [13:0] dac_code;
    logic        upd_pulse, frame_err, pad_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Frame model state
    logic [13:0] exp_code = 14'h0000;
    logic        exp_pad = 1'b0;
    int          upd_at, err_at;

    always #2 clk = ~clk;

    sdac_front u_sdac_front (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .bipolar_sel(bipolar_sel),
        .csn_in(csn_in), .sclk_in(sclk_in), .sdi_in(sdi_in),
        .dac_code(dac_code), .upd_pulse(upd_pulse), .frame_err(frame_err),
        .pad_flag(pad_flag)
    );

    // Vector: {bit count[4:0], 16-bit word}, sent MSB first
    localparam int NVEC = 10;
    localparam logic [20:0] VEC [NVEC] = '{
        {5'd16, 16'hFFFC},
        {5'd16, 16'h0004},
        {5'd16, 16'hAAA8},
        {5'd15, 16'h1234},
        {5'd17, 16'h5554},
        {5'd16, 16'h8000},
        {5'd0,  16'hFFFF},
        {5'd16, 16'h5557},
        {5'd16, 16'h9990},
        {5'd16, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Close the frame, then record the falling-edge index of each strobe.
    task automatic close_and_watch();
        csn_in = 1'b1;
        upd_at = 0;
        err_at = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (upd_pulse) upd_at = (upd_at == 0) ? k : 99;
            if (frame_err) err_at = (err_at == 0) ? k : 99;
        end
    endtask

    // Drop frame select and send nbits bits, the first from bit 15 of w.
    task automatic send_bits(input logic [15:0] w, input int nbits);
        csn_in = 1'b0;
        wait_neg(4);
        for (int i = 0; i < nbits; i++) begin
            sdi_in = (i < 16) ? w[15-i] : 1'b0;
            wait_neg(2);
            sclk_in = 1'b1;
            wait_neg(4);
            sclk_in = 1'b0;
            wait_neg(2);
        end
        wait_neg(2);
    endtask

    initial begin
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(2);

        // Reset state, unipolar strap
        chk("R6 reset code unipolar", dac_code, 14'h0000);
        chk("R6 reset upd", upd_pulse, 1'b0);
        chk("R6 reset err", frame_err, 1'b0);
        chk("R4 reset pad flag", pad_flag, 1'b0);

        // Table of frames against the model
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] w;
            int n;
            w = VEC[v][15:0];
            n = int'(VEC[v][20:16]);
            send_bits(w, n);
            close_and_watch();
            if (n == 16) begin
                exp_code = w[15:2];
                exp_pad = |w[1:0];
                chk("R2 update strobe at cycle 4", upd_at, 4);
                chk("R8 no error on good frame", err_at, 0);
            end else begin
                chk("R3 no update on bad length", upd_at, 0);
                chk("R3 error strobe at cycle 4", err_at, 4);
            end
            chk("R1 latch value", dac_code, exp_code);
            chk("R4 pad flag", pad_flag, exp_pad);
        end

        // Serial clocks with frame select high are ignored
        for (int i = 0; i < 5; i++) begin
            sdi_in = 1'b1;
            sclk_in = 1'b1;
            wait_neg(4);
            sclk_in = 1'b0;
            wait_neg(4);
        end
        chk("R9 idle clocks no update", upd_pulse, 1'b0);
        chk("R9 idle clocks no error", frame_err, 1'b0);
        chk("R9 idle clocks code kept", dac_code, exp_code);

        // Aborted frame, then a good frame restarts the count
        send_bits(16'hFFFF, 5);
        close_and_watch();
        chk("R3 aborted frame error", err_at, 4);
        chk("R3 aborted frame code kept", dac_code, exp_code);
        send_bits(16'h3218, 16);
        close_and_watch();
        exp_code = 14'h0C86;
        chk("R9 restart after abort", upd_at, 4);
        chk("R9 restart code", dac_code, exp_code);

        // Asynchronous clear acts before any clock edge
        clr_n = 1'b0;
        #1;
        chk("R5 async clear unipolar", dac_code, 14'h0000);
        wait_neg(3);

        // Frame while clear is held low
        send_bits(16'h7FFC, 16);
        close_and_watch();
        chk("R7 no update during clear", upd_at, 0);
        chk("R7 code held at reset during clear", dac_code, 14'h0000);
        clr_n = 1'b1;
        wait_neg(6);
        chk("R7 code after clear release", dac_code, 14'h0000);
        send_bits(16'h1238, 16);
        close_and_watch();
        chk("R7 update after clear release", upd_at, 4);
        chk("R7 code after clear release frame", dac_code, 14'h048E);

        // Bipolar strap: reset and clear go to midscale
        bipolar_sel = 1'b1;
        rst_n = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        chk("R6 reset code bipolar", dac_code, 14'h2000);
        chk("R6 reset clears pad flag", pad_flag, 1'b0);
        send_bits(16'hFFFF, 16);
        close_and_watch();
        chk("R4 bipolar full scale code", dac_code, 14'h3FFF);
        chk("R4 pad flag from ones", pad_flag, 1'b1);
        clr_n = 1'b0;
        #1;
        chk("R5 async clear bipolar", dac_code, 14'h2000);
        wait_neg(3);
        clr_n = 1'b1;
        wait_neg(4);
        chk("R6 bipolar code after clear", dac_code, 14'h2000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule